// File: doc/BRIEF.md
# Multi-master RAM port arbiter

This block shares one 32-bit on-chip SRAM port among a CPU master and seven DMA request ports that belong to peripherals. These are a USB device controller, an ADC, a radio MAC, and the receive and transmit directions of two serial controllers. Each port presents a request together with an address, a write flag, an access size and lane-positioned write data. The block picks one port per access and holds that choice until the access ends. It drives byte enables into the memory and returns a completion strobe to the chosen port, with the full read word or an error flag.

DMA ports always beat the CPU, and they rank among themselves by a fixed ladder. A CPU that lost one arbitration wins the next one, so it is never delayed by more than one DMA access. The RAM occupies a window based at 0x20000000. Its size is set by a parameter in kilobytes; production builds use 32 or 64, and the default is kept small for simulation. A fast-clock mode input adds exactly one wait state to every access. The memory is modelled as a synchronous array inside the block.

Top module: `ramarb_top`

## Requirements
- R1: At most one bit of `gnt_o` is high. A granted port keeps its grant through the whole access, and that access ends with exactly one `ack_o` pulse, to the same port, in the cycle after the grant falls.
- R2: Port 0 is the CPU. Ports 1 to 7 are DMA channels ranked from highest to lowest: 1 USB device, 2 ADC, 3 serial controller 2 receive, 4 serial controller 2 transmit, 5 radio MAC, 6 serial controller 1 receive, 7 serial controller 1 transmit. Among eligible DMA ports, the lowest port number wins.
- R3: The CPU wins only when no DMA port is eligible, or when it was eligible and lost the previous arbitration. It is therefore served after at most one DMA access.
- R4: When the block is idle, a rising edge that sees any eligible request grants it. In normal mode, `ack_o` is high for one cycle after the following edge. If `fast_clk_i` was high at the granting edge, the ack comes one cycle later. Back-to-back accesses are therefore spaced 2 or 3 cycles apart.
- R5: Size code 0 is a byte, code 1 a half word, and codes 2 and 3 a word. A byte write enables lane `addr[1:0]`. A half-word write enables lanes 1:0 when `addr[1]` is 0 and lanes 3:2 otherwise. A word write enables all four lanes. Lane n is carried on `wdata[8n+7:8n]`.
- R6: A read returns the whole 32-bit word at `addr[31:2]`, whatever the size, on `rdata_o` during its ack cycle.
- R7: An address whose bits above the RAM size differ from those of 0x20000000 is out of range. Such an access completes on the usual schedule with `err_o` high and `rdata_o` zero, and it writes nothing.
- R8: The block arbitrates again only in the cycle after an ack. A port whose ack is high in that cycle is not eligible, even if its request is still high.
- R9: During and right after reset, `gnt_o`, `ack_o` and `err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_clk_i | input | 1 | High-speed clock mode: one wait state per access |
| req_i | input | 8 | Request per port, held until acked |
| addr_i | input | 8x32 | Byte address per port |
| we_i | input | 8 | Write flag per port |
| size_i | input | 8x2 | Access size per port |
| wdata_i | input | 8x32 | Lane-positioned write data per port |
| gnt_o | output | 8 | One-hot owner of the access in progress |
| ack_o | output | 8 | Completion pulse per port |
| rdata_o | output | 32 | Read word during the ack cycle |
| err_o | output | 1 | Out-of-range flag during the ack cycle |

## Verification
The hardest case to reach is a CPU that is still waiting while several DMA ports keep arriving. The same scene must also arise with requesters that drop their request late, after their ack, and in both clock modes. The stimulus raises random subsets of all eight ports at the same edge. In half of the rounds, requests stay high for one cycle past their ack. A bench model replays each round to predict the grant order, each ack's cycle, and the memory contents. Targeted rounds stack lane-sized writes into one word and aim writes just past the end of the window.

// File: rtl/ramarb_pkg.sv
// Package: shared constants and types for the RAM port arbiter.
// Assumes a 32-bit data path and a RAM window at a fixed base address.
package ramarb_pkg;

    localparam int          DATA_W   = 32;
    localparam int          LANES    = DATA_W / 8;
    localparam logic [31:0] RAM_BASE = 32'h2000_0000;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACC  = 2'd2
    } arb_state_e;

endpackage

// File: rtl/ramarb_prio.sv
// Module: picks the next owner of the RAM port.
// Port 0 is the CPU; ports 1..NREQ-1 are DMA channels, lower index ranks higher.
// Assumes the caller has already removed ports that may not compete.
module ramarb_prio #(
    parameter int NREQ = 8,
    localparam int IDXW = $clog2(NREQ)
) (
    input  logic [NREQ-1:0] elig_i,
    input  logic            cpu_wait_i,
    output logic            any_o,
    output logic [IDXW-1:0] win_o
);

    logic            dma_hit;
    logic [IDXW-1:0] dma_idx;

    // Find the highest-ranked eligible DMA channel.
    always_comb begin
        dma_hit = 1'b0;
        dma_idx = '0;
        for (int i = NREQ - 1; i >= 1; i--) begin
            if (elig_i[i]) begin
                dma_hit = 1'b1;
                dma_idx = IDXW'(i);
            end
        end
    end

    // CPU wins when no DMA competes or when it has already been passed over once.
    always_comb begin
        any_o = |elig_i;
        if (elig_i[0] && (!dma_hit || cpu_wait_i)) begin
            win_o = '0;
        end else begin
            win_o = dma_idx;
        end
    end

endmodule

// File: rtl/ramarb_lanes.sv
// Module: derives byte-lane enables from access size and the low address bits.
// Assumes little-endian lane numbering; misaligned half/word accesses are aligned down.
module ramarb_lanes
    import ramarb_pkg::*;
(
    input  acc_size_e        size_i,
    input  logic [1:0]       addr_lo_i,
    output logic [LANES-1:0] be_o
);

    // Decode the lanes touched by one access.
    always_comb begin
        unique case (size_i)
            SZ_BYTE: be_o = 4'b0001 << addr_lo_i;
            SZ_HALF: be_o = addr_lo_i[1] ? 4'b1100 : 4'b0011;
            default: be_o = 4'b1111;
        endcase
    end

endmodule

// File: rtl/ramarb_sram.sv
// Module: synchronous single-port RAM model, one storage array per byte lane.
// Assumes en is a single-cycle strobe; the read word is registered on the enabling edge.
module ramarb_sram
    import ramarb_pkg::*;
#(
    parameter int WORDS = 1024,
    localparam int IW = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [LANES-1:0]  be_i,
    input  logic [IW-1:0]     idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [7:0] lane_mem [WORDS];
        logic [7:0] lane_rd;

        // Write the lane when enabled, and register its read byte.
        always_ff @(posedge clk) begin
            if (en_i) begin
                if (we_i && be_i[b]) begin
                    lane_mem[idx_i] <= wdata_i[8*b +: 8];
                end
                lane_rd <= lane_mem[idx_i];
            end
        end

        assign rdata_o[8*b +: 8] = lane_rd;
    end

endmodule

// File: rtl/ramarb_top.sv
// Module: RAM port arbiter top. Grants one of NUM_DMA+1 masters per access,
// adds one wait state in fast-clock mode, and range-checks the RAM window.
// Assumes each requester holds its request and fields stable until acked.
module ramarb_top
    import ramarb_pkg::*;
#(
    parameter int NUM_DMA = 7,
    parameter int RAM_KB  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fast_clk_i,
    input  logic [NUM_DMA:0]        req_i,
    input  logic [NUM_DMA:0][31:0]  addr_i,
    input  logic [NUM_DMA:0]        we_i,
    input  logic [NUM_DMA:0][1:0]   size_i,
    input  logic [NUM_DMA:0][31:0]  wdata_i,
    output logic [NUM_DMA:0]        gnt_o,
    output logic [NUM_DMA:0]        ack_o,
    output logic [31:0]             rdata_o,
    output logic                    err_o
);

    localparam int NREQ      = NUM_DMA + 1;
    localparam int IDXW      = $clog2(NREQ);
    localparam int RAM_BYTES = RAM_KB * 1024;
    localparam int OFFW      = $clog2(RAM_BYTES);
    localparam int WORDS     = RAM_BYTES / 4;

    arb_state_e        state_q;
    logic [IDXW-1:0]   owner_q;
    logic [31:0]       addr_q;
    logic              we_q;
    acc_size_e         size_q;
    logic [31:0]       wdata_q;
    logic              cpu_wait_q;
    logic [NREQ-1:0]   ack_q;
    logic              err_q;

    logic [NREQ-1:0]   elig;
    logic              any_req;
    logic [IDXW-1:0]   win;
    logic [LANES-1:0]  be;
    logic              in_range;
    logic [31:0]       sram_rd;

    // Ports acked this cycle sit out the arbitration at the end of it.
    assign elig = req_i & ~ack_q;

    ramarb_prio #(.NREQ(NREQ)) u_prio (
        .elig_i     (elig),
        .cpu_wait_i (cpu_wait_q),
        .any_o      (any_req),
        .win_o      (win)
    );

    ramarb_lanes u_lanes (
        .size_i    (size_q),
        .addr_lo_i (addr_q[1:0]),
        .be_o      (be)
    );

    // Window check: upper address bits must equal those of the RAM base.
    assign in_range = (addr_q[31:OFFW] == RAM_BASE[31:OFFW]);

    ramarb_sram #(.WORDS(WORDS)) u_sram (
        .clk     (clk),
        .en_i    ((state_q == ST_ACC) && in_range),
        .we_i    (we_q),
        .be_i    (be),
        .idx_i   (addr_q[OFFW-1:2]),
        .wdata_i (wdata_q),
        .rdata_o (sram_rd)
    );

    // Access sequencer: arbitrate when idle, optional wait, then one access cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            owner_q    <= '0;
            addr_q     <= '0;
            we_q       <= 1'b0;
            size_q     <= SZ_WORD;
            wdata_q    <= '0;
            cpu_wait_q <= 1'b0;
            ack_q      <= '0;
            err_q      <= 1'b0;
        end else begin
            ack_q <= '0;
            err_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (any_req) begin
                        owner_q    <= win;
                        addr_q     <= addr_i[win];
                        we_q       <= we_i[win];
                        size_q     <= acc_size_e'(size_i[win]);
                        wdata_q    <= wdata_i[win];
                        cpu_wait_q <= elig[0] && (win != '0);
                        state_q    <= fast_clk_i ? ST_WAIT : ST_ACC;
                    end
                end
                ST_WAIT: state_q <= ST_ACC;
                ST_ACC: begin
                    ack_q[owner_q] <= 1'b1;
                    err_q          <= ~in_range;
                    state_q        <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Grant is the owner decoded while an access is in flight.
    always_comb begin
        gnt_o = '0;
        if (state_q != ST_IDLE) begin
            gnt_o[owner_q] = 1'b1;
        end
    end

    assign ack_o   = ack_q;
    assign err_o   = err_q;
    assign rdata_o = ((|ack_q) && !err_q) ? sram_rd : '0;

endmodule

// File: rtl/ramarb_chk.sv
// Checker: temporal properties of the RAM port arbiter, bound to ramarb_top.
module ramarb_chk #(
    parameter int NREQ = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fast_clk_i,
    input logic [NREQ-1:0] req_i,
    input logic [NREQ-1:0] gnt_o,
    input logic [NREQ-1:0] ack_o,
    input logic [31:0]     rdata_o,
    input logic            err_o
);

    logic [NREQ-1:0] req_d, ack_d, gnt_d;
    logic            fast_d;
    logic [1:0]      cpu_skips;
    logic            new_grant;
    logic            prio_bad;

    // Keep one-cycle copies of inputs seen at the arbitration edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d  <= '0;
            ack_d  <= '0;
            gnt_d  <= '0;
            fast_d <= 1'b0;
        end else begin
            req_d  <= req_i;
            ack_d  <= ack_o;
            gnt_d  <= gnt_o;
            fast_d <= fast_clk_i;
        end
    end

    assign new_grant = (|gnt_o) && !(|gnt_d);

    // Winner must have been eligible and outrank every eligible DMA port.
    always_comb begin
        prio_bad = 1'b0;
        if (gnt_o[0] && !(req_d[0] && !ack_d[0])) prio_bad = 1'b1;
        for (int j = 1; j < NREQ; j++) begin
            if (gnt_o[j]) begin
                if (!(req_d[j] && !ack_d[j])) prio_bad = 1'b1;
                for (int k = 1; k < j; k++) begin
                    if (req_d[k] && !ack_d[k]) prio_bad = 1'b1;
                end
            end
        end
    end

    // Count DMA grants handed out while the CPU stood waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_skips <= '0;
        end else if (new_grant) begin
            if (gnt_o[0] || !(req_d[0] && !ack_d[0])) cpu_skips <= '0;
            else if (cpu_skips != 2'd3) cpu_skips <= cpu_skips + 2'd1;
        end
    end

    assert_gnt_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));
    assert_ack_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));
    assert_gnt_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_o) |=> ((gnt_o == $past(gnt_o)) || ((gnt_o == '0) && (ack_o == $past(gnt_o)))));
    assert_ack_owner_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> (ack_o == $past(gnt_o)));
    assert_dma_ladder_R2: assert property (@(posedge clk) disable iff (!rst_n)
        new_grant |-> !prio_bad);
    assert_cpu_no_starve_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_skips < 2'd2);
    assert_lat_normal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (new_grant && !fast_d) |=> (ack_o == $past(gnt_o)));
    assert_lat_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (new_grant && fast_d) |-> ##2 (ack_o == $past(gnt_o, 2)));
    assert_err_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ((|ack_o) && (rdata_o == '0)));
    assert_no_regrant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        new_grant |-> ((gnt_o & ack_d) == '0));

endmodule

bind ramarb_top ramarb_chk #(.NREQ(NUM_DMA + 1)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fast_clk_i (fast_clk_i),
    .req_i      (req_i),
    .gnt_o      (gnt_o),
    .ack_o      (ack_o),
    .rdata_o    (rdata_o),
    .err_o      (err_o)
);

// File: tb/ramarb_top_tb.sv
// Bench: scoreboard for the RAM port arbiter. A round driver predicts grant
// order, ack cycles and memory contents; a monitor pops and compares on acks.
module ramarb_top_tb;
    import ramarb_pkg::*;

    localparam int ND    = 7;
    localparam int NR    = ND + 1;
    localparam int KB    = 4;
    localparam int RB    = KB * 1024;
    localparam int OFFW  = $clog2(RB);
    localparam int WORDS = RB / 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                fast = 1'b0;
    logic [NR-1:0]       req = '0;
    logic [NR-1:0]       we = '0;
    logic [NR-1:0][31:0] addr = '0;
    logic [NR-1:0][31:0] wdata = '0;
    logic [NR-1:0][1:0]  size = '0;
    logic [NR-1:0]       gnt, ack;
    logic [31:0]         rdata;
    logic                err;

    ramarb_top #(.NUM_DMA(ND), .RAM_KB(KB)) u_dut (
        .clk(clk), .rst_n(rst_n), .fast_clk_i(fast),
        .req_i(req), .addr_i(addr), .we_i(we), .size_i(size), .wdata_i(wdata),
        .gnt_o(gnt), .ack_o(ack), .rdata_o(rdata), .err_o(err)
    );

    always #5 clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    typedef struct {
        int          idx;
        bit          rd;
        logic [31:0] data;
        bit          err;
        longint      cyc;
    } exp_t;
    exp_t q[$];

    logic [31:0] ref_mem [WORDS];
    bit          m_wait = 1'b0;

    logic [NR-1:0][31:0] s_addr, s_wdata;
    logic [NR-1:0]       s_we;
    logic [NR-1:0][1:0]  s_size;

    function automatic logic [3:0] lanes_of(input logic [1:0] sz, input logic [1:0] a);
        if (sz == 2'd0) return 4'b0001 << a;
        if (sz == 2'd1) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    // Monitor: compare each ack against the oldest predicted completion.
    always @(negedge clk) begin
        if (rst_n && (ack != '0)) begin
            exp_t e;
            if (q.size() == 0) begin
                check(1'b0, "R1", "ack with nothing pending", 32'(ack), 32'h0);
            end else begin
                e = q.pop_front();
                check(ack == (NR'(1) << e.idx), "R2", "acked port", 32'(ack), 32'(1) << e.idx);
                check(cyc == e.cyc, "R4", "ack cycle", 32'(cyc), 32'(e.cyc));
                check(err == e.err, "R7", "error flag", 32'(err), 32'(e.err));
                if (e.rd) check(rdata == e.data, e.err ? "R7" : "R6", "read word", rdata, e.data);
            end
        end
    end

    task automatic stage(input int p, input bit w, input logic [31:0] a,
                         input logic [1:0] sz, input logic [31:0] d);
        s_we[p] = w; s_addr[p] = a; s_size[p] = sz; s_wdata[p] = d;
    endtask

    // Drive one round of simultaneous requests and predict its outcome.
    task automatic run_round(input logic [NR-1:0] mask, input bit lazy);
        logic [NR-1:0] pend, prev;
        longint base;
        int lat, k, remaining;
        @(negedge clk);
        for (int i = 0; i < NR; i++) begin
            if (mask[i]) begin
                addr[i] = s_addr[i]; we[i] = s_we[i];
                size[i] = s_size[i]; wdata[i] = s_wdata[i];
            end
        end
        req = mask;
        base = cyc;
        lat = fast ? 3 : 2;
        pend = mask;
        k = 0;
        while (pend != '0) begin
            int w;
            bit dma;
            exp_t e;
            logic [31:0] a, m;
            logic [3:0] be;
            int wi;
            dma = |pend[NR-1:1];
            if (pend[0] && (!dma || m_wait)) begin
                w = 0; m_wait = 1'b0;
            end else begin
                w = 0;
                for (int i = NR - 1; i >= 1; i--) if (pend[i]) w = i;
                m_wait = pend[0];
            end
            pend[w] = 1'b0;
            k++;
            a = s_addr[w];
            e.idx = w; e.rd = !s_we[w]; e.cyc = base + k * lat; e.data = '0;
            e.err = (a[31:OFFW] != RAM_BASE[31:OFFW]);
            if (!e.err) begin
                wi = int'(a[OFFW-1:2]);
                be = lanes_of(s_size[w], a[1:0]);
                for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
                if (s_we[w]) ref_mem[wi] = (ref_mem[wi] & ~m) | (s_wdata[w] & m);
                else e.data = ref_mem[wi];
            end
            q.push_back(e);
        end
        remaining = $countones(mask);
        prev = '0;
        while (remaining > 0) begin
            @(negedge clk);
            if (lazy) req = req & ~prev;
            else req = req & ~ack;
            prev = ack;
            if (ack != '0) remaining--;
        end
        if (lazy) begin
            @(negedge clk);
            req = req & ~prev;
        end
    endtask

    function automatic logic [31:0] rand_addr();
        int r;
        r = $urandom % 16;
        if (r == 0) return RAM_BASE + RB + ($urandom % 64);
        if (r == 1) return RAM_BASE - 32'd4 + ($urandom % 4);
        if (r == 2) return RAM_BASE + RB - 4 + ($urandom % 4);
        return RAM_BASE + ($urandom % 256);
    endfunction

    initial begin
        for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(gnt == '0, "R9", "grant in reset", 32'(gnt), 32'h0);
        check(ack == '0, "R9", "ack in reset", 32'(ack), 32'h0);
        check(err == 1'b0, "R9", "error in reset", 32'(err), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(gnt == '0 && ack == '0, "R9", "idle after reset", 32'(gnt), 32'h0);

        // Fill the region the stimulus touches (R4 single-requester latency).
        for (int w = 0; w <= 64; w++) begin
            int wi;
            wi = (w == 64) ? WORDS - 1 : w;
            stage(0, 1'b1, RAM_BASE + 32'(wi * 4), 2'd2, 32'hC0DE_0000 + 32'(wi));
            run_round(NR'(1), 1'b0);
        end

        // R2/R3: all ports at once, CPU should come second.
        for (int p = 0; p < NR; p++) stage(p, 1'b0, RAM_BASE + 32'(p * 4), 2'd2, '0);
        run_round('1, 1'b0);

        // R5: byte lanes from four DMA ports, then half words, then word reads (R6).
        for (int p = 1; p <= 4; p++)
            stage(p, 1'b1, RAM_BASE + 32'h10 + 32'(p - 1), 2'd0, {4{8'(8'h11 * p)}});
        run_round(NR'(8'b0001_1110), 1'b0);
        stage(0, 1'b0, RAM_BASE + 32'h12, 2'd0, '0);
        run_round(NR'(1), 1'b0);
        stage(5, 1'b1, RAM_BASE + 32'h22, 2'd1, 32'hABCD_1234);
        stage(6, 1'b1, RAM_BASE + 32'h25, 2'd1, 32'h5566_7788);
        run_round(NR'(8'b0110_0000), 1'b0);
        stage(0, 1'b0, RAM_BASE + 32'h20, 2'd2, '0);
        stage(7, 1'b0, RAM_BASE + 32'h24, 2'd3, '0);
        run_round(NR'(8'b1000_0001), 1'b0);

        // R7: writes past the window and below it must not alias onto word 0.
        stage(2, 1'b1, RAM_BASE + RB, 2'd2, 32'hDEAD_BEEF);
        stage(3, 1'b1, RAM_BASE - 4, 2'd2, 32'hFEED_F00D);
        stage(7, 1'b0, RAM_BASE + RB + 8, 2'd2, '0);
        run_round(NR'(8'b1000_1100), 1'b0);
        stage(0, 1'b0, RAM_BASE, 2'd2, '0);
        stage(1, 1'b0, RAM_BASE + RB - 4, 2'd2, '0);
        run_round(NR'(8'b0000_0011), 1'b0);

        // R4: fast-clock mode with every port contending.
        fast = 1'b1;
        for (int p = 0; p < NR; p++) stage(p, 1'b0, RAM_BASE + 32'(p * 4 + 32), 2'd2, '0);
        run_round('1, 1'b0);
        // R8: late-dropping requesters in both modes.
        run_round('1, 1'b1);
        fast = 1'b0;
        run_round('1, 1'b1);

        // Random contention rounds.
        for (int r = 0; r < 300; r++) begin
            logic [NR-1:0] mask;
            mask = NR'($urandom);
            if (mask == '0) mask = NR'(1);
            fast = $urandom % 2;
            for (int p = 0; p < NR; p++)
                stage(p, $urandom % 2, rand_addr(), 2'($urandom), $urandom);
            run_round(mask, $urandom % 2);
        end

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R1", "unacked predictions left", 32'(q.size()), 32'h0);
        check(gnt == '0, "R1", "grant after drain", 32'(gnt), 32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R1", "watchdog expired", 32'(cyc), 32'h0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule